// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block turns an asynchronous serial line into parallel characters. A sample-clock enable (`tick`), running at sixteen times the bit rate, paces a receiver that finds each start bit, samples every following bit at its centre and checks parity and the stop bit. Each completed character goes into a receive queue together with its own parity, framing and break flags.

The queue holds sixteen characters when queue mode is on. With queue mode off, it acts as a single-character holding buffer. The flags of the character at the head of the queue are always visible at the outputs. An overrun flag stays set until the host reads line status.

The interrupt request combines three sources: data available or trigger level reached, character timeout, and line errors. `rxrdy` tells a DMA-style reader that data is waiting. When the queue is in use, a finished character enters the queue three sample periods after its stop bit is sampled. With the queue off, it enters one sample period after. All occupancy-based outputs follow that entry.

Top module: `uart_rx_fifo`

## Requirements
- R1: `data_bits` selects the character length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first and appear right-aligned on `rd_data`, with unused upper bits at zero.
- R2: When `parity_en` is 1, one parity bit follows the data. `parity_even`=1 expects an even count of ones over the data and parity bits, and 0 expects an odd count. A mismatch sets `err_parity` for that character.
- R3: A stop bit sampled low sets `err_frame` for that character.
- R4: If the line stays low from the start bit through the stop-bit sample, exactly one character is stored. It has data 0x00 with `err_break`=1 and `err_frame`=1. No further character is taken until the line has returned high and falls again.
- R5: A start bit is accepted only if the line is still low at the eighth tick after the falling edge. A shorter low pulse stores nothing.
- R6: With `fifo_en`=0, `data_ready` rises one tick after the stop-bit sample. That is 1 + 8 + 16·(frame bits − 1) + 1 ticks after the falling edge of the start bit, where frame bits counts start, data, parity and stop bits. `irq` follows it and clears after the character is read with `rd_strobe`.
- R7: With `fifo_en`=1, up to 16 characters are kept in arrival order. `trig_sel` codes 0, 1, 2 and 3 select levels 1, 4, 8 and 14. `irq` and `rxrdy` assert when the stored count reaches the level.
- R8: A character that completes while the buffer is full is dropped, and the stored characters are kept. It sets `err_overrun` and `irq`, and both stay set until an `lsr_rd` pulse.
- R9: With `fifo_en`=1, `data_ready` rises three ticks after the stop-bit sample, two ticks later than in R6.
- R10: With `fifo_en`=1, the timeout asserts `irq` and `rxrdy` when the buffer is non-empty but below the trigger level, and nothing has been stored or read for 64·(frame bits) + 8 ticks. A read clears it.
- R11: After reset the buffer is empty, and all flags, `rxrdy` and `irq` are 0.
- R12: Parity, framing and break flags belong to the head character. After a read they show the next character's flags at once. A stored character with any of these flags set raises `irq` until `lsr_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample enable at 16x bit rate |
| rxd | input | 1 | Serial input line, idle high |
| data_bits | input | 2 | Character length code (5 + code bits) |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 = even parity, 0 = odd |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single buffer; a change empties the buffer |
| trig_sel | input | 2 | Trigger level code (1, 4, 8, 14) |
| rd_strobe | input | 1 | One-cycle pulse: remove head character |
| lsr_rd | input | 1 | One-cycle pulse: line status read, clears overrun and error interrupt |
| rd_data | output | 8 | Head character |
| data_ready | output | 1 | Buffer non-empty |
| err_parity | output | 1 | Head character parity error |
| err_frame | output | 1 | Head character framing error |
| err_break | output | 1 | Head character is a break |
| err_overrun | output | 1 | Sticky overrun |
| rxrdy | output | 1 | Data-waiting indication for a block reader |
| irq | output | 1 | Receive interrupt request |

## Verification
Two events can fall in the same clock: a delayed character entry into the queue and a host read of the head entry. Another case is an entry arriving while the queue is full, just as the host reads line status. The bench fills the queue past capacity and then drains it. It interleaves flagged and clean characters so that a read exposes the next head's flags. It judges the result from the order of the data read back, the sticky overrun, and the flag values seen in the cycle after each read.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH      = 16,
  parameter int FIFO_LAG   = 3,
  parameter int TOUT_CHARS = 4,
  parameter int TOUT_EXTRA = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] data_bits,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       fifo_en,
  input  logic [1:0] trig_sel,
  input  logic       rd_strobe,
  input  logic       lsr_rd,
  output logic [7:0] rd_data,
  output logic       data_ready,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_break,
  output logic       err_overrun,
  output logic       rxrdy,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int LW = $clog2(FIFO_LAG + 1);
  localparam int TW = $clog2(TOUT_CHARS * 16 * 12 + TOUT_EXTRA + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t         st;
  logic [3:0]  cnt;
  logic [2:0]  bidx;
  logic [7:0]  sh;
  logic        pbit, rxd_q;
  logic        stg_v;
  logic [LW-1:0] stg_lag;
  logic [10:0] stg_w, new_word;
  logic [10:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, limit, trig;
  logic        fen_q, oe, err_irq;
  logic [TW-1:0] tcnt, tlimit;

  wire [2:0] nb_m1      = 3'd4 + {1'b0, data_bits};
  wire [3:0] frame_bits = 4'd7 + {2'b0, data_bits} + {3'b0, parity_en};
  wire stop_done = tick && st == S_STOP && cnt == 4'd15;
  wire flush     = fifo_en != fen_q;
  wire push      = stg_v && tick && stg_lag == '0;
  wire full      = count >= limit;
  wire do_wr     = push && !full;
  wire ovr       = push && full;
  wire pop       = rd_strobe && count != '0;
  wire tout      = tcnt == tlimit;
  wire exp_par   = parity_even ? ^sh : ~^sh;
  wire brk       = sh == 8'h00 && !(parity_en && pbit) && !rxd;
  wire [10:0] head = mem[rp];

  assign limit  = fifo_en ? CW'(DEPTH) : CW'(1);
  assign tlimit = TW'(TOUT_CHARS * 16) * TW'(frame_bits) + TW'(TOUT_EXTRA);

  always_comb begin
    case (trig_sel)
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(4);
      2'd2:    trig = CW'(8);
      default: trig = CW'(14);
    endcase
    if (brk) new_word = {1'b1, 1'b1, 1'b0, 8'h00};
    else     new_word = {1'b0, !rxd, parity_en && (pbit != exp_par), sh};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; sh <= '0; pbit <= 1'b0; rxd_q <= 1'b1;
    end else if (tick) begin
      rxd_q <= rxd;
      cnt   <= cnt + 4'd1;
      case (st)
        S_IDLE: if (!rxd && rxd_q) begin st <= S_START; cnt <= '0; end
        S_START:
          if (cnt == 4'd7) begin
            cnt <= '0;
            if (rxd) st <= S_IDLE;
            else begin st <= S_DATA; bidx <= '0; sh <= '0; end
          end
        S_DATA:
          if (cnt == 4'd15) begin
            sh[bidx] <= rxd;
            bidx <= bidx + 3'd1;
            if (bidx == nb_m1) st <= parity_en ? S_PAR : S_STOP;
          end
        S_PAR:  if (cnt == 4'd15) begin pbit <= rxd; st <= S_STOP; end
        S_STOP: if (cnt == 4'd15) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v <= 1'b0; stg_lag <= '0; stg_w <= '0;
    end else if (stop_done) begin
      stg_v   <= 1'b1;
      stg_lag <= fifo_en ? LW'(FIFO_LAG - 1) : '0;
      stg_w   <= new_word;
    end else if (push) begin
      stg_v <= 1'b0;
    end else if (stg_v && tick) begin
      stg_lag <= stg_lag - LW'(1);
    end
  end

  always_ff @(posedge clk)
    if (do_wr && !flush) mem[wp] <= stg_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; fen_q <= 1'b0;
    end else begin
      fen_q <= fifo_en;
      if (flush) begin
        wp <= '0; rp <= '0; count <= '0;
      end else begin
        if (do_wr) wp <= wp + AW'(1);
        if (pop)   rp <= rp + AW'(1);
        count <= count + CW'(do_wr) - CW'(pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe <= 1'b0; err_irq <= 1'b0;
    end else begin
      if (ovr) oe <= 1'b1;
      else if (lsr_rd) oe <= 1'b0;
      if (ovr || (do_wr && |stg_w[10:8])) err_irq <= 1'b1;
      else if (lsr_rd) err_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !fifo_en || count == '0 || do_wr || pop) tcnt <= '0;
    else if (tick && !tout) tcnt <= tcnt + TW'(1);
  end

  wire rda = fifo_en ? (count >= trig) : (count != '0);

  assign data_ready  = count != '0;
  assign rd_data     = data_ready ? head[7:0] : 8'h00;
  assign err_parity  = data_ready && head[8];
  assign err_frame   = data_ready && head[9];
  assign err_break   = data_ready && head[10];
  assign err_overrun = oe;
  assign rxrdy       = fifo_en ? (rda || tout) : data_ready;
  assign irq         = rda || tout || err_irq;

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_single_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !flush) |-> count <= CW'(1));
  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !pop && !flush) |=> (count == $past(count)) && err_overrun);
  assert_pop_decrements_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !do_wr && !flush) |=> count == $past(count) - CW'(1));
  assert_tout_has_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tout |-> (fifo_en && data_ready));
endmodule

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1;
  logic [1:0] data_bits = 2'd3, trig_sel = 2'd0;
  logic parity_en = 1'b0, parity_even = 1'b0, fifo_en = 1'b0;
  logic rd_strobe = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic data_ready, err_parity, err_frame, err_break, err_overrun, rxrdy, irq;

  int checks = 0, failures = 0, cyc = 0, t0 = 0, seen_at = 0;
  bit arm = 0, seen = 0, done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (arm && data_ready && !seen) begin seen = 1; seen_at = cyc; end

  uart_rx_fifo u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit par_of(input logic [7:0] d, input int nb, input bit even);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += d[i];
    return even ? ones[0] : !ones[0];
  endfunction

  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit pb, input bit stopv);
    rxd = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; repeat (16) @(negedge clk); end
    if (pen) begin rxd = pb; repeat (16) @(negedge clk); end
    rxd = stopv; repeat (16) @(negedge clk);
    rxd = 1'b1; repeat (16) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] d, output logic [2:0] fl);
    d = rd_data; fl = {err_break, err_frame, err_parity};
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic lsr();
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] db, input bit pen, input bit pev, input bit fen, input logic [1:0] tr);
    logic [7:0] d; logic [2:0] f;
    data_bits = db; parity_en = pen; parity_even = pev; fifo_en = fen; trig_sel = tr;
    repeat (2) @(negedge clk);
    while (data_ready) rd(d, f);
    lsr();
  endtask

  task automatic t_reset();
    chk("R11 data_ready", data_ready, 0);
    chk("R11 irq", irq, 0);
    chk("R11 rxrdy", rxrdy, 0);
    chk("R11 flags", {err_break, err_frame, err_parity, err_overrun}, 0);
  endtask

  task automatic t_lengths();
    logic [7:0] d; logic [2:0] f;
    for (int nb = 5; nb <= 8; nb++) begin
      cfg(2'(nb - 5), 0, 0, 0, 0);
      send(8'hE5, nb, 0, 0, 1);
      rd(d, f);
      chk("R1 data", d, 8'hE5 & ((1 << nb) - 1));
      chk("R1 flags clean", f, 0);
    end
  endtask

  task automatic t_parity();
    logic [7:0] d; logic [2:0] f;
    cfg(2'd2, 1, 1, 0, 0);
    send(8'h35, 7, 1, par_of(8'h35, 7, 1), 1);
    chk("R2 even ok pe", err_parity, 0);
    rd(d, f);
    chk("R2 even ok data", d, 8'h35);
    send(8'h35, 7, 1, !par_of(8'h35, 7, 1), 1);
    chk("R2 even bad pe", err_parity, 1);
    chk("R12 error irq", irq, 1);
    rd(d, f); lsr();
    chk("R12 irq after lsr", irq, 0);
    cfg(2'd3, 1, 0, 0, 0);
    send(8'h0F, 8, 1, par_of(8'h0F, 8, 0), 1);
    chk("R2 odd ok pe", err_parity, 0);
    rd(d, f);
  endtask

  task automatic t_frame();
    logic [7:0] d; logic [2:0] f;
    cfg(2'd3, 0, 0, 0, 0);
    send(8'h5A, 8, 0, 0, 0);
    rd(d, f);
    chk("R3 fe", f, 3'b010);
    chk("R3 data", d, 8'h5A);
  endtask

  task automatic t_break();
    logic [7:0] d; logic [2:0] f;
    cfg(2'd3, 0, 0, 0, 0);
    rxd = 1'b0; repeat (400) @(negedge clk);
    rxd = 1'b1; repeat (32) @(negedge clk);
    chk("R4 stored", data_ready, 1);
    rd(d, f);
    chk("R4 flags bi fe", f, 3'b110);
    chk("R4 data zero", d, 0);
    chk("R4 single entry", data_ready, 0);
  endtask

  task automatic t_glitch();
    cfg(2'd3, 0, 0, 0, 0);
    rxd = 1'b0; repeat (5) @(negedge clk);
    rxd = 1'b1; repeat (200) @(negedge clk);
    chk("R5 glitch ignored", data_ready, 0);
  endtask

  task automatic t_latency(input bit fen);
    logic [7:0] d; logic [2:0] f;
    cfg(2'd3, 0, 0, fen, 0);
    seen = 0; t0 = cyc; arm = 1;
    send(8'hC3, 8, 0, 0, 1);
    arm = 0;
    if (fen) chk("R9 fifo latency", seen_at - t0, 156);
    else begin
      chk("R6 latency", seen_at - t0, 154);
      chk("R6 irq set", irq, 1);
    end
    rd(d, f);
    chk(fen ? "R9 data" : "R6 data", d, 8'hC3);
    chk(fen ? "R9 irq clear" : "R6 irq clear", irq, 0);
  endtask

  task automatic t_trigger();
    logic [7:0] d; logic [2:0] f;
    cfg(2'd3, 0, 0, 1, 2'd1);
    for (int i = 0; i < 3; i++) send(8'(8'h40 + i), 8, 0, 0, 1);
    chk("R7 below trigger irq", irq, 0);
    chk("R7 below trigger rxrdy", rxrdy, 0);
    send(8'h43, 8, 0, 0, 1);
    chk("R7 at trigger irq", irq, 1);
    chk("R7 at trigger rxrdy", rxrdy, 1);
    for (int i = 0; i < 4; i++) begin rd(d, f); chk("R7 order", d, 8'h40 + i); end
  endtask

  task automatic t_overrun();
    logic [7:0] d; logic [2:0] f;
    cfg(2'd3, 0, 0, 1, 2'd3);
    for (int i = 0; i < 17; i++) send(8'(i), 8, 0, 0, 1);
    chk("R8 overrun set", err_overrun, 1);
    chk("R8 irq", irq, 1);
    for (int i = 0; i < 16; i++) begin rd(d, f); chk("R8 kept order", d, i); end
    chk("R8 extra dropped", data_ready, 0);
    chk("R8 sticky", err_overrun, 1);
    lsr();
    chk("R8 cleared", err_overrun, 0);
    cfg(2'd3, 0, 0, 0, 0);
    send(8'hA1, 8, 0, 0, 1);
    send(8'hA2, 8, 0, 0, 1);
    chk("R8 single overrun", err_overrun, 1);
    rd(d, f);
    chk("R8 single keeps first", d, 8'hA1);
    chk("R8 single empty", data_ready, 0);
    lsr();
  endtask

  task automatic t_track();
    logic [7:0] d; logic [2:0] f;
    cfg(2'd3, 1, 1, 1, 2'd3);
    send(8'h11, 8, 1, par_of(8'h11, 8, 1), 1);
    send(8'h22, 8, 1, !par_of(8'h22, 8, 1), 1);
    send(8'h33, 8, 1, par_of(8'h33, 8, 1), 1);
    chk("R12 err irq", irq, 1);
    lsr();
    chk("R12 irq cleared", irq, 0);
    chk("R12 head clean", err_parity, 0);
    rd(d, f);
    chk("R12 next head pe", err_parity, 1);
    chk("R12 next head data", rd_data, 8'h22);
    rd(d, f);
    chk("R12 third clean", err_parity, 0);
    rd(d, f);
  endtask

  task automatic t_timeout();
    logic [7:0] d; logic [2:0] f;
    cfg(2'd3, 0, 0, 1, 2'd1);
    send(8'h77, 8, 0, 0, 1);
    repeat (600) @(negedge clk);
    chk("R10 before timeout", irq, 0);
    repeat (40) @(negedge clk);
    chk("R10 timeout irq", irq, 1);
    chk("R10 timeout rxrdy", rxrdy, 1);
    rd(d, f);
    chk("R10 data", d, 8'h77);
    chk("R10 cleared", irq, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    checks++; failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_lengths();
    t_parity();
    t_frame();
    t_break();
    t_glitch();
    t_latency(0);
    t_latency(1);
    t_trigger();
    t_overrun();
    t_track();
    t_timeout();
    finish_run();
  end
endmodule